// File: doc/BRIEF.md
# Configuration Port FIFO Bridge

This block connects a host register bus to a device configuration port, moving 32-bit words in both directions. To send configuration data, the host pushes words into a deep outbound FIFO and then sets a control bit. The bridge then presents those words to the port one at a time until the FIFO runs dry. To read configuration data back, the host loads a word count into a 12-bit size register and sets a second control bit. The bridge then accepts that many words from the port into a shallower inbound FIFO, which the host drains by reading a data address.

The host can also read how much space is left in the outbound FIFO and how many words wait in the inbound FIFO. A status word carries a done flag, which is low while a transfer runs or while the port reports busy, together with the port's error, alignment and abort signals. Two level-held control bits are provided. One flushes both FIFOs. The other is a soft reset that also clears the size register and abandons any transfer. Software sets each of these bits with one write and clears it with a second write.

The host side uses single-cycle write strobes. A read returns its data on `host_rdata` one cycle after `host_rd`. The port side uses valid/ready handshakes in each direction.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset, status reads 0x3F when the port inputs are idle (abort_n=1, others 0). Vacancy reads WR_DEPTH, and occupancy, size and control all read 0.
- R2: A host write to 0x100 appends the word to the outbound FIFO, and the write is dropped when the FIFO holds WR_DEPTH words. Address 0x114 reads WR_DEPTH minus the number of stored words.
- R3: Writing control (0x10C) with bit 0 set while idle starts a drain. `cp_tx_valid` then shows the oldest stored word whenever the FIFO is non-empty, and a word leaves on each cycle where valid and ready are both high. The drain ends when the FIFO is empty, and done is 1 again from the cycle after the last accepted word.
- R4: Writing control with bit 1 set while idle starts a readback of the current size value. `cp_rx_ready` is high only while the readback runs, the inbound FIFO (depth RD_DEPTH) has room and words remain. Exactly the size count of words is stored, and a size of 0 finishes at once. Occupancy is read at 0x118.
- R5: A host read of 0x104 returns the oldest inbound word and removes it. When the inbound FIFO is empty, the read returns 0 and occupancy stays 0.
- R6: Start bits written while a transfer runs are ignored. When bits 0 and 1 are written together, the drain is chosen.
- R7: Control bit 2 (clear) flushes both FIFOs and drops any push while it stays set. Control reads back bits 3 and 2, and bits 1 and 0 always read 0.
- R8: While control bit 3 (soft reset) is set, both FIFOs are empty, size reads 0 and any transfer is abandoned.
- R9: Status (0x110) has done in bit 0, ones in bits 4..1, abort_n in bit 5, readback-running in bit 6, aligned in bit 7 and config error in bit 8. Done is 1 only when no transfer runs and `cp_busy` is low.
- R10: Size (0x108) stores the low 12 bits of the written word and reads them back.
- R11: Read data appears on `host_rdata` the cycle after `host_rd` and holds until the next read. Unmapped addresses and 0x100 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 9 | Host register byte address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 32 | Registered host read data |
| cp_tx_valid | output | 1 | Outbound word valid |
| cp_tx_ready | input | 1 | Port accepts outbound word |
| cp_tx_data | output | 32 | Outbound word |
| cp_rx_valid | input | 1 | Port offers inbound word |
| cp_rx_ready | output | 1 | Bridge accepts inbound word |
| cp_rx_data | input | 32 | Inbound word |
| cp_busy | input | 1 | Port busy |
| cp_abort_n | input | 1 | Port abort indication, active low |
| cp_aligned | input | 1 | Port data-aligned flag |
| cp_cfg_err | input | 1 | Port configuration error |

## Verification
The bench builds the bridge with an 8-word outbound FIFO and a 4-word inbound FIFO and keeps the 12-bit size. At these depths, overfilling the outbound side takes only ten writes. A six-word readback runs into a full inbound FIFO, so the stall and resume of `cp_rx_ready` are exercised while the host drains words in the middle of a transfer. The 12-bit size field and the register addresses match the full-size build, so truncation of the size value and address decoding are tested exactly as they would behave in the full-size build.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int ADDR_W = 9;
  localparam logic [ADDR_W-1:0] A_WFIFO = 9'h100;
  localparam logic [ADDR_W-1:0] A_RFIFO = 9'h104;
  localparam logic [ADDR_W-1:0] A_SIZE  = 9'h108;
  localparam logic [ADDR_W-1:0] A_CTRL  = 9'h10C;
  localparam logic [ADDR_W-1:0] A_STAT  = 9'h110;
  localparam logic [ADDR_W-1:0] A_WVAC  = 9'h114;
  localparam logic [ADDR_W-1:0] A_ROCC  = 9'h118;
  localparam int C_WR_GO = 0;
  localparam int C_RD_GO = 1;
  localparam int C_FLUSH = 2;
  localparam int C_SRST  = 3;
  typedef enum logic [1:0] {ENG_IDLE, ENG_WR, ENG_RD} eng_state_t;
endpackage

// File: rtl/cfgb_fifo.sv
module cfgb_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign rdata   = mem[rptr_q];
  assign count   = cnt_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q + CW'(push_ok) - CW'(pop_ok);
    if (push_ok) wptr_d = step(wptr_q);
    if (pop_ok)  rptr_d = step(rptr_q);
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end
endmodule

// File: rtl/cfgb_engine.sv
module cfgb_engine
  import cfgb_pkg::*;
#(
  parameter int WR_DEPTH = 1024,
  parameter int SIZE_W = 12,
  localparam int WCW = $clog2(WR_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic [SIZE_W-1:0] size,
  input  logic [WCW-1:0]    wf_count,
  input  logic              wf_empty,
  input  logic              rf_full,
  input  logic              tx_ready,
  input  logic              rx_valid,
  output logic              tx_valid,
  output logic              tx_fire,
  output logic              rx_ready,
  output logic              rx_fire,
  output logic              idle,
  output logic              rd_active,
  output logic [SIZE_W-1:0] rem
);
  eng_state_t        state_q, state_d;
  logic [SIZE_W-1:0] rem_q, rem_d;

  assign tx_valid  = (state_q == ENG_WR) & ~wf_empty;
  assign tx_fire   = tx_valid & tx_ready;
  assign rx_ready  = (state_q == ENG_RD) & ~rf_full & (rem_q != '0);
  assign rx_fire   = rx_ready & rx_valid;
  assign idle      = (state_q == ENG_IDLE);
  assign rd_active = (state_q == ENG_RD);
  assign rem       = rem_q;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    case (state_q)
      ENG_IDLE: begin
        if (start_wr) begin
          state_d = ENG_WR;
        end else if (start_rd) begin
          state_d = ENG_RD;
          rem_d   = size;
        end
      end
      ENG_WR: begin
        if (wf_empty || (wf_count == WCW'(1) && tx_fire)) state_d = ENG_IDLE;
      end
      ENG_RD: begin
        if (rem_q == '0 || (rem_q == SIZE_W'(1) && rx_fire)) state_d = ENG_IDLE;
        if (rx_fire) rem_d = rem_q - 1'b1;
      end
      default: state_d = ENG_IDLE;
    endcase
    if (abort) begin
      state_d = ENG_IDLE;
      rem_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
    end
  end
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgb_pkg::*;
#(
  parameter int WR_DEPTH = 1024,
  parameter int RD_DEPTH = 256,
  parameter int SIZE_W = 12,
  parameter int DATA_W = 32,
  localparam int WCW = $clog2(WR_DEPTH + 1),
  localparam int RCW = $clog2(RD_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  output logic              cp_tx_valid,
  input  logic              cp_tx_ready,
  output logic [DATA_W-1:0] cp_tx_data,
  input  logic              cp_rx_valid,
  output logic              cp_rx_ready,
  input  logic [DATA_W-1:0] cp_rx_data,
  input  logic              cp_busy,
  input  logic              cp_abort_n,
  input  logic              cp_aligned,
  input  logic              cp_cfg_err
);
  logic rst_meta, rst_q;
  logic flush_q, srst_q, flush_d, srst_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic wr_ctrl, wr_size, wf_push, rf_pop, fifo_flush;
  logic [WCW-1:0] wf_count;
  logic [RCW-1:0] rf_count;
  logic wf_full, wf_empty, rf_full, rf_empty;
  logic [DATA_W-1:0] rf_rdata;
  logic tx_fire, rx_fire, eng_idle, rd_active, done;
  logic [SIZE_W-1:0] eng_rem;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  assign wr_ctrl    = host_wr & (host_addr == A_CTRL);
  assign wr_size    = host_wr & (host_addr == A_SIZE);
  assign wf_push    = host_wr & (host_addr == A_WFIFO);
  assign rf_pop     = host_rd & (host_addr == A_RFIFO);
  assign fifo_flush = flush_q | srst_q;
  assign done       = eng_idle & ~cp_busy;

  cfgb_fifo #(.DEPTH(WR_DEPTH), .W(DATA_W)) u_wfifo (
    .clk(clk), .rst_n(rst_q), .flush(fifo_flush), .push(wf_push), .wdata(host_wdata),
    .pop(tx_fire), .rdata(cp_tx_data), .count(wf_count), .full(wf_full), .empty(wf_empty));

  cfgb_fifo #(.DEPTH(RD_DEPTH), .W(DATA_W)) u_rfifo (
    .clk(clk), .rst_n(rst_q), .flush(fifo_flush), .push(rx_fire), .wdata(cp_rx_data),
    .pop(rf_pop), .rdata(rf_rdata), .count(rf_count), .full(rf_full), .empty(rf_empty));

  cfgb_engine #(.WR_DEPTH(WR_DEPTH), .SIZE_W(SIZE_W)) u_engine (
    .clk(clk), .rst_n(rst_q), .abort(srst_q),
    .start_wr(wr_ctrl & host_wdata[C_WR_GO]), .start_rd(wr_ctrl & host_wdata[C_RD_GO]),
    .size(size_q), .wf_count(wf_count), .wf_empty(wf_empty), .rf_full(rf_full),
    .tx_ready(cp_tx_ready), .rx_valid(cp_rx_valid), .tx_valid(cp_tx_valid),
    .tx_fire(tx_fire), .rx_ready(cp_rx_ready), .rx_fire(rx_fire),
    .idle(eng_idle), .rd_active(rd_active), .rem(eng_rem));

  always_comb begin
    flush_d = flush_q;
    srst_d  = srst_q;
    size_d  = size_q;
    if (wr_ctrl) begin
      flush_d = host_wdata[C_FLUSH];
      srst_d  = host_wdata[C_SRST];
    end
    if (srst_q) size_d = '0;
    else if (wr_size) size_d = host_wdata[SIZE_W-1:0];
  end

  always_comb begin
    rdata_d = '0;
    case (host_addr)
      A_RFIFO: rdata_d = rf_empty ? '0 : rf_rdata;
      A_SIZE:  rdata_d = DATA_W'(size_q);
      A_CTRL:  rdata_d[C_SRST:C_FLUSH] = {srst_q, flush_q};
      A_STAT:  rdata_d[8:0] = {cp_cfg_err, cp_aligned, rd_active, cp_abort_n, 4'hF, done};
      A_WVAC:  rdata_d = DATA_W'(WR_DEPTH) - DATA_W'(wf_count);
      A_ROCC:  rdata_d = DATA_W'(rf_count);
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      flush_q <= 1'b0;
      srst_q  <= 1'b0;
      size_q  <= '0;
      rdata_q <= '0;
    end else begin
      flush_q <= flush_d;
      srst_q  <= srst_d;
      size_q  <= size_d;
      if (host_rd) rdata_q <= rdata_d;
    end
  end

  assign host_rdata = rdata_q;
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker
  import cfgb_pkg::*;
#(
  parameter int WR_DEPTH = 1024,
  parameter int RD_DEPTH = 256,
  parameter int SIZE_W = 12,
  localparam int WCW = $clog2(WR_DEPTH + 1),
  localparam int RCW = $clog2(RD_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic              cp_tx_valid,
  input logic              cp_rx_valid,
  input logic              cp_rx_ready,
  input logic              done,
  input logic [WCW-1:0]    wf_count,
  input logic [RCW-1:0]    rf_count,
  input logic [SIZE_W-1:0] rem
);
  assert_wf_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wf_count) <= WR_DEPTH);

  assert_tx_not_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cp_tx_valid |-> !done);

  assert_rx_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cp_rx_ready |-> int'(rf_count) < RD_DEPTH);

  assert_rem_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_rx_valid && cp_rx_ready && !soft_rst) |=> rem == $past(rem) - SIZE_W'(1));

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == A_RFIFO && rf_count == '0 && !cp_rx_ready) |=> rf_count == '0);

  assert_srst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rem == '0 && wf_count == '0 && rf_count == '0));
endmodule

bind cfg_port_bridge cfgb_checker #(.WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .soft_rst(srst_q), .host_rd(host_rd), .host_addr(host_addr),
  .cp_tx_valid(cp_tx_valid), .cp_rx_valid(cp_rx_valid), .cp_rx_ready(cp_rx_ready),
  .done(done), .wf_count(wf_count), .rf_count(rf_count), .rem(eng_rem));

// File: tb/cfg_port_bridge_bench.sv
module cfg_port_bridge_bench;
  localparam int WR_D = 8;
  localparam int RD_D = 4;
  localparam logic [8:0] A_WF = 9'h100, A_RF = 9'h104, A_SZ = 9'h108, A_CR = 9'h10C;
  localparam logic [8:0] A_SR = 9'h110, A_WV = 9'h114, A_RO = 9'h118;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [8:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        cp_tx_valid, cp_rx_ready;
  logic        cp_tx_ready = 1'b0, cp_rx_valid = 1'b0;
  logic [31:0] cp_tx_data;
  logic [31:0] cp_rx_data = '0;
  logic        cp_busy = 1'b0, cp_abort_n = 1'b1, cp_aligned = 1'b0, cp_cfg_err = 1'b0;

  cfg_port_bridge #(.WR_DEPTH(WR_D), .RD_DEPTH(RD_D), .SIZE_W(12), .DATA_W(32)) u_cfg_port_bridge (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .cp_tx_valid(cp_tx_valid), .cp_tx_ready(cp_tx_ready),
    .cp_tx_data(cp_tx_data), .cp_rx_valid(cp_rx_valid), .cp_rx_ready(cp_rx_ready),
    .cp_rx_data(cp_rx_data), .cp_busy(cp_busy), .cp_abort_n(cp_abort_n),
    .cp_aligned(cp_aligned), .cp_cfg_err(cp_cfg_err));

  int checks = 0, fails = 0;
  bit cmp_on = 1'b0, run_done = 1'b0;

  // behavioural reference model
  logic [31:0] wq[$];
  logic [31:0] rq[$];
  logic [31:0] tx_log[$];
  int m_mode = 0;  // 0 idle, 1 drain, 2 readback
  int m_rem = 0, m_size = 0, wsz = 0;
  bit m_clr = 0, m_rst = 0, m_rd_pend = 0, clr0 = 0, rst0 = 0, txf = 0, rxf = 0, hpush = 0, hpop = 0;
  logic [31:0] m_rdata = '0;
  logic [31:0] port_ctr = 32'h100;

  function automatic bit m_txv();
    return m_mode == 1 && wq.size() > 0;
  endfunction
  function automatic bit m_rxr();
    return m_mode == 2 && rq.size() < RD_D && m_rem != 0;
  endfunction
  function automatic logic [31:0] m_read(input logic [8:0] a);
    logic [31:0] v = '0;
    case (a)
      A_RF: v = (rq.size() > 0) ? rq[0] : 32'h0;
      A_SZ: v = 32'(m_size);
      A_CR: v = {28'h0, m_rst, m_clr, 2'b00};
      A_SR: v = {23'h0, cp_cfg_err, cp_aligned, (m_mode == 2), cp_abort_n, 4'hF,
                 (m_mode == 0 && !cp_busy)};
      A_WV: v = 32'(WR_D - wq.size());
      A_RO: v = 32'(rq.size());
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      wq.delete(); rq.delete();
      m_mode = 0; m_rem = 0; m_size = 0; m_clr = 0; m_rst = 0; m_rd_pend = 0;
      port_ctr = 32'h100;
    end else begin
      clr0 = m_clr; rst0 = m_rst;
      txf = m_txv() && cp_tx_ready;
      rxf = m_rxr() && cp_rx_valid;
      wsz = wq.size();
      if (cp_tx_valid && cp_tx_ready) tx_log.push_back(cp_tx_data);
      m_rd_pend = host_rd;
      if (host_rd) m_rdata = m_read(host_addr);
      hpush = host_wr && host_addr == A_WF && wq.size() < WR_D;
      hpop  = host_rd && host_addr == A_RF && rq.size() > 0;
      if (clr0 || rst0) begin
        wq.delete(); rq.delete();
      end else begin
        if (txf) void'(wq.pop_front());
        if (hpush) wq.push_back(host_wdata);
        if (hpop) void'(rq.pop_front());
        if (rxf) rq.push_back(cp_rx_data);
      end
      if (rst0) begin
        m_mode = 0; m_rem = 0;
      end else begin
        case (m_mode)
          0: if (host_wr && host_addr == A_CR && host_wdata[0]) m_mode = 1;
             else if (host_wr && host_addr == A_CR && host_wdata[1]) begin m_mode = 2; m_rem = m_size; end
          1: if (wsz == 0 || (wsz == 1 && txf)) m_mode = 0;
          2: begin
               if (m_rem == 0 || (m_rem == 1 && rxf)) m_mode = 0;
               if (rxf) m_rem--;
             end
          default: m_mode = 0;
        endcase
      end
      if (rst0) m_size = 0;
      else if (host_wr && host_addr == A_SZ) m_size = int'(host_wdata[11:0]);
      if (host_wr && host_addr == A_CR) begin m_clr = host_wdata[2]; m_rst = host_wdata[3]; end
      if (cp_rx_valid && cp_rx_ready) port_ctr++;
    end
  end

  always @(negedge clk) cp_rx_data <= port_ctr;

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 tx_valid", {31'h0, cp_tx_valid}, {31'h0, m_txv()});
      if (m_txv()) chk("R3 tx_data", cp_tx_data, wq[0]);
      chk("R4 rx_ready", {31'h0, cp_rx_ready}, {31'h0, m_rxr()});
      if (m_rd_pend) chk("R11 rdata vs model", host_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask
  task automatic rd_get(input logic [8:0] a, output logic [31:0] v);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0; v = host_rdata;
  endtask
  task automatic rd_chk(input logic [8:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd_get(a, v);
    chk(tag, v, exp);
  endtask
  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd_get(A_SR, v);
      if (v[0]) break;
    end
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!run_done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(3); cmp_on = 1'b1;
    // reset state
    rd_chk(A_SR, 32'h3F, "R1 status");
    rd_chk(A_WV, 32'd8, "R1 vacancy");
    rd_chk(A_RO, 32'd0, "R1 occupancy");
    rd_chk(A_SZ, 32'd0, "R1 size");
    rd_chk(A_CR, 32'd0, "R1 control");
    // overfill outbound FIFO
    for (int i = 1; i <= 10; i++) wr(A_WF, 32'(i));
    rd_chk(A_WV, 32'd0, "R2 vacancy full");
    // drain with port stalled, then a start of readback while busy
    wr(A_CR, 32'h1);
    rd_chk(A_SR, 32'h3E, "R3 done low in drain");
    wr(A_CR, 32'h2);
    rd_chk(A_SR, 32'h3E, "R6 start ignored while busy");
    rd_chk(A_CR, 32'h0, "R7 start bits read 0");
    cp_tx_ready = 1'b1;
    wait_done();
    chk("R3 drained count", 32'(tx_log.size()), 32'd8);
    for (int i = 0; i < 8 && i < tx_log.size(); i++) chk("R3 drained order", tx_log[i], 32'(i + 1));
    rd_chk(A_WV, 32'd8, "R2 vacancy after drain");
    // readback of 6 words through a 4-word FIFO
    cp_rx_valid = 1'b1;
    wr(A_SZ, 32'd6);
    wr(A_CR, 32'h2);
    idle(10);
    rd_chk(A_RO, 32'd4, "R4 occupancy stalls at depth");
    rd_chk(A_SR, 32'h7E, "R9 readback running");
    for (int i = 0; i < 6; i++) rd_chk(A_RF, 32'h100 + 32'(i), "R5 inbound order");
    idle(4);
    rd_chk(A_SR, 32'h3F, "R4 done after size words");
    rd_chk(A_RF, 32'h0, "R5 empty read returns 0");
    rd_chk(A_RO, 32'd0, "R5 empty read keeps occupancy");
    // size truncation
    wr(A_SZ, 32'h1FFF);
    rd_chk(A_SZ, 32'hFFF, "R10 size 12 bits");
    // zero-length readback
    wr(A_SZ, 32'd0);
    wr(A_CR, 32'h2);
    idle(2);
    rd_chk(A_SR, 32'h3F, "R4 zero size finishes");
    rd_chk(A_RO, 32'd0, "R4 zero size stores nothing");
    // both start bits: drain wins
    tx_log.delete();
    cp_tx_ready = 1'b0;
    wr(A_WF, 32'hA1); wr(A_WF, 32'hA2);
    wr(A_CR, 32'h3);
    rd_chk(A_SR, 32'h3E, "R6 drain chosen over readback");
    rd_chk(A_RO, 32'd0, "R6 no readback words");
    cp_tx_ready = 1'b1;
    wait_done();
    chk("R6 drained count", 32'(tx_log.size()), 32'd2);
    if (tx_log.size() == 2) begin
      chk("R6 drained word0", tx_log[0], 32'hA1);
      chk("R6 drained word1", tx_log[1], 32'hA2);
    end
    // FIFO clear
    cp_tx_ready = 1'b0;
    wr(A_WF, 32'h11); wr(A_WF, 32'h12); wr(A_WF, 32'h13);
    wr(A_CR, 32'h4);
    idle(2);
    rd_chk(A_WV, 32'd8, "R7 clear empties outbound");
    rd_chk(A_CR, 32'h4, "R7 clear bit reads back");
    wr(A_WF, 32'h55);
    rd_chk(A_WV, 32'd8, "R7 push dropped during clear");
    wr(A_CR, 32'h0);
    rd_chk(A_CR, 32'h0, "R7 clear released");
    // soft reset in the middle of a readback
    cp_rx_valid = 1'b0;
    wr(A_SZ, 32'd10);
    wr(A_CR, 32'h2);
    rd_chk(A_SR, 32'h7E, "R8 readback started");
    wr(A_WF, 32'h7);
    wr(A_CR, 32'h8);
    idle(2);
    rd_chk(A_SR, 32'h3F, "R8 transfer abandoned");
    rd_chk(A_SZ, 32'h0, "R8 size cleared");
    rd_chk(A_WV, 32'd8, "R8 outbound flushed");
    rd_chk(A_CR, 32'h8, "R8 reset bit reads back");
    wr(A_CR, 32'h0);
    rd_chk(A_CR, 32'h0, "R8 reset released");
    // status inputs
    cp_busy = 1'b1;
    rd_chk(A_SR, 32'h3E, "R9 busy holds done low");
    cp_busy = 1'b0; cp_abort_n = 1'b0; cp_aligned = 1'b1; cp_cfg_err = 1'b1;
    rd_chk(A_SR, 32'h19F, "R9 status flag positions");
    cp_abort_n = 1'b1; cp_aligned = 1'b0; cp_cfg_err = 1'b0;
    // unmapped and write-only addresses
    rd_chk(9'h0C0, 32'h0, "R11 unmapped reads 0");
    rd_chk(A_WF, 32'h0, "R11 outbound data reads 0");
    idle(2);
    chk("R11 rdata holds", host_rdata, 32'h0);
    cmp_on = 1'b0;
    run_done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule